// File: doc/BRIEF.md
# Loss-Priority Output Cell Queue

This block is the descriptor queue of one switch output port. Each arriving cell brings a descriptor word and a one-bit loss-priority flag. A flag value of 1 marks the cell as discardable first. Cells leave strictly in arrival order on a valid/ready dequeue port. When space runs short, low-priority cells are the ones that are lost. A high-priority arrival at a full queue evicts one queued low-priority cell, and a selector decides whether the evicted cell is the oldest or the newest of them. Two admission limits hold back room for high-priority traffic: a shared-occupancy threshold and a cap on the number of queued low-priority cells.

The arrival side has no back-pressure. Every presented cell is decided in the cycle it is presented, and it is either admitted or dropped. On the dequeue side, `out_desc` and `out_clp` show the head whenever `out_valid` is high, and the head leaves on a cycle where `out_valid` and `out_ready` are both high. A stalled head with flag 0 is never replaced. A stalled head with flag 1 can be evicted by a push-out. Saturating counters and live occupancy figures are plain outputs.

Top module: `cell_prio_queue`

## Requirements
- R1: Dequeued descriptors appear in the arrival order of the cells that survive. `out_valid` is high exactly when the queue is non-empty. A stalled head with flag 0 stays unchanged.
- R2: A dequeue in a cycle is applied before that cycle's arrival. A flag-0 arrival at a full queue that is dequeued in the same cycle is admitted without any push-out.
- R3: A flag-0 arrival at a full queue evicts one queued flag-1 cell and is admitted. If no flag-1 cell is queued, the arrival is dropped.
- R4: With `cfg_push_tail`=0 the evicted cell is the oldest queued flag-1 cell, and with `cfg_push_tail`=1 it is the newest. The survivors keep their order, and the new cell goes at the tail.
- R5: A flag-1 arrival at a full queue (after any same-cycle dequeue) is dropped and never evicts anything.
- R6: A flag-1 arrival is dropped when the occupancy after any same-cycle dequeue is greater than `cfg_share_thr`.
- R7: A flag-1 arrival is dropped when the number of queued flag-1 cells after any same-cycle dequeue is at least `cfg_lo_cap`.
- R8: `cnt_accepted` counts admitted arrivals, including those that cause an eviction. `cnt_dropped` counts dropped arrivals. `cnt_pushed` counts evictions. Each counter stops at its all-ones value.
- R9: `occupancy` gives the number of queued cells and `lo_count` gives the number of queued flag-1 cells. Both update in the cycle after an event.
- R10: After reset the queue is empty, `out_valid` is low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arrival present this cycle |
| in_desc | input | DESC_W | Arriving descriptor |
| in_clp | input | 1 | Arriving loss-priority flag (1 = low priority) |
| out_valid | output | 1 | Head descriptor available |
| out_ready | input | 1 | Consumer takes the head this cycle |
| out_desc | output | DESC_W | Head descriptor |
| out_clp | output | 1 | Head loss-priority flag |
| cfg_push_tail | input | 1 | Eviction choice: 0 oldest, 1 newest flag-1 cell |
| cfg_share_thr | input | OCC_W | Occupancy above which flag-1 arrivals are dropped |
| cfg_lo_cap | input | OCC_W | Maximum number of queued flag-1 cells |
| occupancy | output | OCC_W | Queued cell count |
| lo_count | output | OCC_W | Queued flag-1 cell count |
| cnt_accepted | output | CNT_W | Saturating admitted-arrival count |
| cnt_dropped | output | CNT_W | Saturating dropped-arrival count |
| cnt_pushed | output | CNT_W | Saturating eviction count |

## Verification
A wrong eviction index or a slip in compaction does not change `occupancy`. It shows up only when the queue drains, as a descriptor out of order or a flag-1 cell where a flag-0 cell was expected. That can be many cycles after the fault, so directed cases fill the queue, evict and then drain at once. A wrong admission decision is visible one cycle later in `occupancy`, `lo_count` and the counters. A lost or doubled flag bit is visible at once in `lo_count`.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ADMIT,
    ACT_DROP,
    ACT_PUSH
  } arrival_act_e;
endpackage

// File: rtl/cpq_victim.sv
// Picks which queued low-priority slot is evicted: lowest index (oldest) or highest (newest).
module cpq_victim #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] lo_mask,
  input  logic             pick_newest,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = |lo_mask;
    if (pick_newest) begin
      for (int i = 0; i < DEPTH; i++)
        if (lo_mask[i]) idx = IDX_W'(i);
    end else begin
      for (int i = DEPTH - 1; i >= 0; i--)
        if (lo_mask[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cpq_admit.sv
// Arrival decision, taken on the state left after any same-cycle dequeue.
module cpq_admit
  import cpq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OCC_W = 4
) (
  input  logic             arr_valid,
  input  logic             arr_lo,
  input  logic [OCC_W-1:0] occ_after,
  input  logic [OCC_W-1:0] lo_after,
  input  logic [OCC_W-1:0] share_thr,
  input  logic [OCC_W-1:0] lo_cap,
  input  logic             victim_found,
  output arrival_act_e     act
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  always_comb begin
    act = ACT_NONE;
    if (arr_valid) begin
      if (arr_lo) begin
        if (occ_after == FULL || occ_after > share_thr || lo_after >= lo_cap)
          act = ACT_DROP;
        else
          act = ACT_ADMIT;
      end else if (occ_after != FULL) begin
        act = ACT_ADMIT;
      end else if (victim_found) begin
        act = ACT_PUSH;
      end else begin
        act = ACT_DROP;
      end
    end
  end
endmodule

// File: rtl/cpq_store.sv
// Ordered slot array, slot 0 is the head. Handles shift-on-dequeue, append and
// remove-and-compact in a single cycle.
module cpq_store #(
  parameter int DESC_W = 16,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int OCC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deq,
  input  logic              wr,
  input  logic              push,
  input  logic [IDX_W-1:0]  victim,
  input  logic [DESC_W-1:0] wr_desc,
  input  logic              wr_clp,
  output logic [DESC_W-1:0] head_desc,
  output logic              head_clp,
  output logic [DEPTH-1:0]  clp_vec,
  output logic [OCC_W-1:0]  occ
);
  logic [DESC_W-1:0] desc_q [DEPTH];
  logic              clp_q  [DEPTH];
  logic [DESC_W-1:0] desc_n [DEPTH];
  logic              clp_n  [DEPTH];
  logic [OCC_W-1:0]  wpos;

  assign wpos = occ - OCC_W'(deq);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      automatic int up = (i < DEPTH - 1) ? i + 1 : i;
      desc_n[i] = desc_q[i];
      clp_n[i]  = clp_q[i];
      if (push) begin
        if (i == DEPTH - 1) begin
          desc_n[i] = wr_desc;
          clp_n[i]  = wr_clp;
        end else if (i >= int'(victim)) begin
          desc_n[i] = desc_q[up];
          clp_n[i]  = clp_q[up];
        end
      end else begin
        if (deq) begin
          desc_n[i] = desc_q[up];
          clp_n[i]  = (i < DEPTH - 1) ? clp_q[up] : 1'b0;
        end
        if (wr && int'(wpos) == i) begin
          desc_n[i] = wr_desc;
          clp_n[i]  = wr_clp;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        desc_q[i] <= '0;
        clp_q[i]  <= 1'b0;
      end
    end else begin
      occ <= occ - OCC_W'(deq) + OCC_W'(wr);
      for (int i = 0; i < DEPTH; i++) begin
        desc_q[i] <= desc_n[i];
        clp_q[i]  <= clp_n[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vec
    assign clp_vec[g] = clp_q[g];
  end

  assign head_desc = desc_q[0];
  assign head_clp  = clp_q[0];
endmodule

// File: rtl/cpq_sat_counter.sv
module cpq_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (bump && count != '1)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/cell_prio_queue.sv
module cell_prio_queue
  import cpq_pkg::*;
#(
  parameter int DESC_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DESC_W-1:0] in_desc,
  input  logic              in_clp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DESC_W-1:0] out_desc,
  output logic              out_clp,
  input  logic              cfg_push_tail,
  input  logic [OCC_W-1:0]  cfg_share_thr,
  input  logic [OCC_W-1:0]  cfg_lo_cap,
  output logic [OCC_W-1:0]  occupancy,
  output logic [OCC_W-1:0]  lo_count,
  output logic [CNT_W-1:0]  cnt_accepted,
  output logic [CNT_W-1:0]  cnt_dropped,
  output logic [CNT_W-1:0]  cnt_pushed
);
  localparam int NUM_CNT = 3;

  logic             deq;
  logic [DEPTH-1:0] clp_vec;
  logic [OCC_W-1:0] occ_after, lo_after;
  logic [IDX_W-1:0] victim_idx;
  logic             victim_found;
  arrival_act_e     act;
  logic [NUM_CNT-1:0] bump;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  assign out_valid = (occupancy != '0);
  assign deq       = out_valid & out_ready;
  assign lo_count  = OCC_W'($countones(clp_vec));
  assign occ_after = occupancy - OCC_W'(deq);
  assign lo_after  = lo_count - OCC_W'(deq & out_clp);

  cpq_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
    .lo_mask    (clp_vec),
    .pick_newest(cfg_push_tail),
    .idx        (victim_idx),
    .found      (victim_found)
  );

  cpq_admit #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_admit (
    .arr_valid   (in_valid),
    .arr_lo      (in_clp),
    .occ_after   (occ_after),
    .lo_after    (lo_after),
    .share_thr   (cfg_share_thr),
    .lo_cap      (cfg_lo_cap),
    .victim_found(victim_found),
    .act         (act)
  );

  cpq_store #(.DESC_W(DESC_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .OCC_W(OCC_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .deq      (deq),
    .wr       (act == ACT_ADMIT),
    .push     (act == ACT_PUSH),
    .victim   (victim_idx),
    .wr_desc  (in_desc),
    .wr_clp   (in_clp),
    .head_desc(out_desc),
    .head_clp (out_clp),
    .clp_vec  (clp_vec),
    .occ      (occupancy)
  );

  assign bump[0] = (act == ACT_ADMIT) || (act == ACT_PUSH);
  assign bump[1] = (act == ACT_DROP);
  assign bump[2] = (act == ACT_PUSH);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    cpq_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (bump[g]),
      .count(cnt_arr[g])
    );
  end

  assign cnt_accepted = cnt_arr[0];
  assign cnt_dropped  = cnt_arr[1];
  assign cnt_pushed   = cnt_arr[2];
endmodule

// File: rtl/cpq_checker.sv
module cpq_checker #(
  parameter int DESC_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_clp,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DESC_W-1:0] out_desc,
  input logic              out_clp,
  input logic [OCC_W-1:0]  occupancy,
  input logic [OCC_W-1:0]  lo_count,
  input logic [CNT_W-1:0]  cnt_dropped,
  input logic [CNT_W-1:0]  cnt_pushed
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  // R1
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !out_clp |=> out_valid && !out_clp && $stable(out_desc));

  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= FULL && lo_count <= occupancy);

  // R5
  lo_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_clp && occupancy == FULL && !out_ready
    |=> $stable(occupancy) && $stable(lo_count) && $stable(cnt_pushed));

  // R3
  hi_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_clp && occupancy == FULL && !out_ready && lo_count != '0
    |=> occupancy == FULL && lo_count == $past(lo_count) - OCC_W'(1));

  // R2
  deq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_clp && out_ready && occupancy == FULL
    |=> occupancy == FULL && $stable(cnt_pushed));

  // R8
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dropped == '1 |=> cnt_dropped == '1);
endmodule

bind cell_prio_queue cpq_checker #(.DESC_W(DESC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_cpq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_clp     (in_clp),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_desc   (out_desc),
  .out_clp    (out_clp),
  .occupancy  (occupancy),
  .lo_count   (lo_count),
  .cnt_dropped(cnt_dropped),
  .cnt_pushed (cnt_pushed)
);

// File: tb/cell_prio_queue_test.sv
`timescale 1ns/1ps
module cell_prio_queue_test;
  localparam int DW    = 8;
  localparam int DEPTH = 6;
  localparam int CW    = 4;
  localparam int OW    = $clog2(DEPTH + 1);
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_clp = 1'b0, out_ready = 1'b0, cfg_tail = 1'b0;
  logic [DW-1:0] in_desc = '0;
  logic [OW-1:0] cfg_thr = OW'(DEPTH), cfg_cap = OW'(DEPTH);
  logic out_valid, out_clp;
  logic [DW-1:0] out_desc;
  logic [OW-1:0] occupancy, lo_count;
  logic [CW-1:0] cnt_accepted, cnt_dropped, cnt_pushed;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  cell_prio_queue #(.DESC_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_desc(in_desc), .in_clp(in_clp),
    .out_valid(out_valid), .out_ready(out_ready), .out_desc(out_desc), .out_clp(out_clp),
    .cfg_push_tail(cfg_tail), .cfg_share_thr(cfg_thr), .cfg_lo_cap(cfg_cap),
    .occupancy(occupancy), .lo_count(lo_count),
    .cnt_accepted(cnt_accepted), .cnt_dropped(cnt_dropped), .cnt_pushed(cnt_pushed)
  );

  // Reference state
  logic [DW-1:0] md [DEPTH];
  logic          mc [DEPTH];
  int mocc = 0, macc = 0, mdrop = 0, mpush = 0;
  string step_tag = "R10";
  string cur_tag = "R1";

  function automatic int sat_inc(input int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  function automatic int model_lo();
    int n = 0;
    for (int k = 0; k < mocc; k++) if (mc[k]) n++;
    return n;
  endfunction

  task automatic model_step(input logic v, input logic clp, input logic [DW-1:0] d, input logic rdy);
    logic full_before, deq_now;
    int lo, vic;
    full_before = (mocc == DEPTH);
    deq_now = (mocc > 0) && rdy;
    step_tag = "R9";
    if (deq_now) begin
      for (int k = 0; k < DEPTH - 1; k++) begin md[k] = md[k+1]; mc[k] = mc[k+1]; end
      mocc--;
    end
    lo = model_lo();
    if (v) begin
      if (full_before && deq_now) step_tag = "R2";
      if (clp) begin
        if (mocc == DEPTH)                 begin mdrop = sat_inc(mdrop); step_tag = "R5"; end
        else if (mocc > int'(cfg_thr))     begin mdrop = sat_inc(mdrop); step_tag = "R6"; end
        else if (lo >= int'(cfg_cap))      begin mdrop = sat_inc(mdrop); step_tag = "R7"; end
        else begin md[mocc] = d; mc[mocc] = 1'b1; mocc++; macc = sat_inc(macc); end
      end else if (mocc < DEPTH) begin
        md[mocc] = d; mc[mocc] = 1'b0; mocc++; macc = sat_inc(macc);
      end else begin
        vic = -1;
        for (int k = 0; k < DEPTH; k++)
          if (mc[k] && (cfg_tail || vic < 0)) vic = k;
        if (vic < 0) begin
          mdrop = sat_inc(mdrop); step_tag = "R3";
        end else begin
          for (int k = vic; k < DEPTH - 1; k++) begin md[k] = md[k+1]; mc[k] = mc[k+1]; end
          md[DEPTH-1] = d; mc[DEPTH-1] = 1'b0;
          macc = sat_inc(macc); mpush = sat_inc(mpush); step_tag = "R4";
        end
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(out_valid == (mocc > 0), "R1", "out_valid", int'(out_valid), int'(mocc > 0));
    if (mocc > 0) begin
      chk(out_desc == md[0], cur_tag, "out_desc", int'(out_desc), int'(md[0]));
      chk(out_clp == mc[0], cur_tag, "out_clp", int'(out_clp), int'(mc[0]));
    end
    chk(int'(occupancy) == mocc, step_tag, "occupancy", int'(occupancy), mocc);
    chk(int'(lo_count) == model_lo(), "R9", "lo_count", int'(lo_count), model_lo());
    chk(int'(cnt_accepted) == macc, "R8", "cnt_accepted", int'(cnt_accepted), macc);
    chk(int'(cnt_dropped) == mdrop, "R8", "cnt_dropped", int'(cnt_dropped), mdrop);
    chk(int'(cnt_pushed) == mpush, "R8", "cnt_pushed", int'(cnt_pushed), mpush);
  endtask

  // Called just after a falling edge: drive, model, wait one cycle, compare.
  task automatic cycle(input logic v, input logic clp, input logic [DW-1:0] d, input logic rdy);
    in_valid = v; in_clp = clp; in_desc = d; out_ready = rdy;
    model_step(v, clp, d, rdy);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drain(input string tag);
    cur_tag = tag;
    repeat (DEPTH + 1) cycle(1'b0, 1'b0, '0, 1'b1);
    cur_tag = "R1";
  endtask

  task automatic fill(input logic [DEPTH-1:0] pattern, input logic [DW-1:0] base);
    for (int k = 0; k < DEPTH; k++) cycle(1'b1, pattern[k], base + DW'(k), 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int k = 0; k < DEPTH; k++) begin md[k] = '0; mc[k] = 1'b0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    step_tag = "R10";
    chk(out_valid == 1'b0, "R10", "out_valid", int'(out_valid), 0);
    chk(occupancy == '0, "R10", "occupancy", int'(occupancy), 0);
    chk(cnt_accepted == '0 && cnt_dropped == '0 && cnt_pushed == '0, "R10", "counters",
        int'(cnt_accepted) + int'(cnt_dropped) + int'(cnt_pushed), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R3/R4: evict oldest flag-1 cells, then drop when none remain
    cfg_tail = 1'b0;
    fill(6'b011010, 8'h10);
    cycle(1'b1, 1'b0, 8'hA0, 1'b0);  // R4 evicts oldest
    cycle(1'b1, 1'b0, 8'hA1, 1'b0);  // R4
    cycle(1'b1, 1'b0, 8'hA2, 1'b0);  // R4
    cycle(1'b1, 1'b0, 8'hA3, 1'b0);  // R3 no flag-1 left: drop
    cycle(1'b1, 1'b1, 8'hA4, 1'b0);  // R5 flag-1 at full dropped
    cycle(1'b1, 1'b0, 8'hA5, 1'b1);  // R2 dequeue first, admit without push
    drain("R4");

    // R4: evict newest flag-1 cell
    cfg_tail = 1'b1;
    fill(6'b101010, 8'h30);
    cycle(1'b1, 1'b0, 8'hB0, 1'b0);
    cycle(1'b1, 1'b0, 8'hB1, 1'b0);
    drain("R4");
    cfg_tail = 1'b0;

    // R6: shared threshold
    cfg_thr = OW'(2);
    repeat (4) cycle(1'b1, 1'b1, 8'h50, 1'b0);
    cycle(1'b1, 1'b0, 8'h51, 1'b0);
    drain("R6");
    cfg_thr = OW'(DEPTH);

    // R7: low-priority cap
    cfg_cap = OW'(1);
    cycle(1'b1, 1'b1, 8'h60, 1'b0);
    cycle(1'b1, 1'b1, 8'h61, 1'b0);
    cycle(1'b1, 1'b0, 8'h62, 1'b0);
    cycle(1'b1, 1'b1, 8'h63, 1'b1);  // head flag-1 leaves same cycle: admitted
    drain("R7");

    // R8: drop counter saturation
    cfg_cap = '0;
    repeat (CMAX + 4) cycle(1'b1, 1'b1, 8'h70, 1'b0);
    chk(int'(cnt_dropped) == CMAX, "R8", "cnt_dropped saturated", int'(cnt_dropped), CMAX);
    cfg_cap = OW'(DEPTH);

    // Random phase
    for (int blk = 0; blk < 20; blk++) begin
      cfg_thr  = OW'($urandom_range(DEPTH, 0));
      cfg_cap  = OW'($urandom_range(DEPTH, 0));
      cfg_tail = 1'($urandom_range(1, 0));
      for (int n = 0; n < 150; n++)
        cycle($urandom_range(99, 0) < 75, 1'($urandom_range(1, 0)),
              DW'($urandom), $urandom_range(99, 0) < 35);
    end
    drain("R1");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule